// File: doc/BRIEF.md
# Clocked 8-bit Serial Shift Interface

This block moves one byte at a time over a synchronous serial link. Software writes a byte into the data register, then writes the mode register with the go bit set. The block then shifts the byte out on the serial output pin while it collects a byte from the serial input pin. When eight bits have moved, the go bit drops, a completion flag rises and, if enabled, an interrupt is requested. The shift clock comes either from a prescaler counting an instruction-cycle tick (period of 2, 8 or 32 ticks) or from an external clock taken in on the clock pin through a two-stage synchronizer. Two enables decide whether the data-out and clock pins carry the serial function or the general-purpose values of the surrounding port.

A controller sequences each transfer through four states. IDLE is the rest state, with the internal clock high. On a go write it moves to LOW when the clock is internal, or to ARM when it is external. ARM waits for the first external falling edge and then enters LOW; that first fall does not shift. LOW holds the clock low and leaves on the end of its half period, or on the external rising edge; at that point the input bit is sampled and the state becomes HIGH. HIGH holds the clock high. At the end of its half period, or on the external falling edge, the register shifts and the state goes back to LOW. After the eighth bit, HIGH instead does a final shift and returns to IDLE: at the end of the half period with the internal clock, or on the next cycle with the external clock. A write of go = 0 while busy leaves any state for IDLE at once.

Top module: `sio8_shifter`

## Requirements
- R1: After reset the mode register (address 0) and the data register (address 1) both read 0x00, and irq is 0.
- R2: Writing the mode register with bit 0 = 1 while idle starts a transfer. Bit 0 reads 1 while the transfer runs and clears by itself after exactly 8 bits.
- R3: The rate field in bits 3:2 sets the bit period with the internal clock: 00 gives 2 ticks, 01 gives 8, 10 gives 32. A transfer lasts 8 periods of tick-enabled cycles. The clock is low for the first half of each bit and high for the second. It idles high, and it does not advance on cycles without a tick.
- R4: Bit 1 = 0 sends data bit 0 first, and bit 1 = 1 sends data bit 7 first. The output changes only on falling clock edges, and the input is sampled on rising edges. After the transfer the data register holds the received byte, with the first received bit in bit 0 (bit 1 = 0) or in bit 7 (bit 1 = 1).
- R5: Rate 11 uses the clock pin as an input through a two-flop synchronizer. Its falling edges advance the output and its rising edges sample the input, and the transfer completes after the eighth rising edge.
- R6: The done flag (bit 7) sets in the same cycle that bit 0 clears at completion. A mode write with bit 7 = 0 clears it, and one with bit 7 = 1 leaves it unchanged.
- R7: irq is 1 exactly while the interrupt enable (bit 6) and the done flag are both 1.
- R8: With bit 4 = 1 the data-out pin carries the serial output bit. With bit 4 = 0 it carries gpio_so_val.
- R9: With bit 5 = 1 the clock pin output carries the internal shift clock and its output enable is 1. With bit 5 = 0 they carry gpio_sck_val and gpio_sck_oe.
- R10: A mode write with bit 0 = 0 during a transfer stops it at once: bit 0 reads 0, the clock returns high and the done flag does not set.
- R11: Data register writes are taken while idle and read back, and are ignored while a transfer runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Instruction-cycle enable for the prescaler |
| reg_addr | input | 1 | Register select: 0 mode, 1 data |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| si_pin | input | 1 | Serial data input |
| sck_pin_i | input | 1 | Clock pin input (external clock) |
| gpio_so_val | input | 1 | Port value for the data-out pin |
| gpio_sck_val | input | 1 | Port value for the clock pin |
| gpio_sck_oe | input | 1 | Port output enable for the clock pin |
| so_pin_o | output | 1 | Data-out pin value |
| sck_pin_o | output | 1 | Clock pin output value |
| sck_pin_oe | output | 1 | Clock pin output enable |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume three things: the rate and bit-order fields are not rewritten during a transfer, the serial input stays steady around the sampling edge, and the external clock is slow compared with the synchronizer latency. The stimulus writes mode fields only while the block is idle or when it means to stop. It changes the input bit half a cycle after each observed falling edge. It drives the external clock with six-cycle half periods, which is longer than the three cycles needed for detection.

// File: rtl/sio8_pkg.sv
`timescale 1ns/1ps
package sio8_pkg;
    localparam int SIO_BITS = 8;
    localparam logic [1:0] RATE_EXT = 2'b11;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_LOW  = 2'd2,
        ST_HIGH = 2'd3
    } sio_state_e;
endpackage

// File: rtl/sio8_clkgen.sv
`timescale 1ns/1ps
module sio8_clkgen #(
    parameter int P_FAST      = 2,
    parameter int P_MID       = 8,
    parameter int P_SLOW      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] rate,
    input  logic       phase_clr,
    input  logic       sck_in,
    output logic       phase_done,
    output logic       ext_rise,
    output logic       ext_fall
);
    localparam int H_FAST = P_FAST / 2;
    localparam int H_MID  = P_MID / 2;
    localparam int H_SLOW = P_SLOW / 2;
    localparam int CNT_W  = (H_SLOW > 1) ? $clog2(H_SLOW) : 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] half_last;
    logic [SYNC_STAGES-1:0] sync_q;
    logic prev_q;

    always_comb begin
        case (rate)
            2'b00:   half_last = CNT_W'(H_FAST - 1);
            2'b01:   half_last = CNT_W'(H_MID - 1);
            default: half_last = CNT_W'(H_SLOW - 1);
        endcase
    end

    assign phase_done = tick && (cnt_q == half_last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (phase_clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (cnt_q == half_last) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // synchronizer chain for the external clock
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sync_q[g] <= 1'b1;
            end else if (g == 0) begin
                sync_q[g] <= sck_in;
            end else begin
                sync_q[g] <= sync_q[(g > 0) ? g - 1 : 0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
        end else begin
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign ext_rise = sync_q[SYNC_STAGES-1] & ~prev_q;
    assign ext_fall = ~sync_q[SYNC_STAGES-1] & prev_q;
endmodule

// File: rtl/sio8_ctrl.sv
`timescale 1ns/1ps
module sio8_ctrl
    import sio8_pkg::*;
#(
    parameter int BITS = 8,
    localparam int CW  = $clog2(BITS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_req,
    input  logic          stop_req,
    input  logic          ext_mode,
    input  logic          phase_done,
    input  logic          ext_rise,
    input  logic          ext_fall,
    output sio_state_e    state,
    output logic          busy,
    output logic          sck_int,
    output logic          phase_clr,
    output logic          sample_en,
    output logic          shift_en,
    output logic          finish,
    output logic [CW-1:0] bit_cnt
);
    sio_state_e state_q, state_d;
    logic [CW-1:0] bit_cnt_q;
    logic adv;
    logic last_bit;

    assign last_bit = (bit_cnt_q == CW'(BITS));

    // event that ends the current state
    always_comb begin
        adv = 1'b0;
        unique case (state_q)
            ST_IDLE: adv = 1'b0;
            ST_ARM:  adv = ext_fall;
            ST_LOW:  adv = ext_mode ? ext_rise : phase_done;
            ST_HIGH: begin
                if (last_bit) begin
                    adv = ext_mode ? 1'b1 : phase_done;
                end else begin
                    adv = ext_mode ? ext_fall : phase_done;
                end
            end
            default: adv = 1'b0;
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_req) begin
                    state_d = ext_mode ? ST_ARM : ST_LOW;
                end
            end
            ST_ARM: begin
                if (stop_req) begin
                    state_d = ST_IDLE;
                end else if (adv) begin
                    state_d = ST_LOW;
                end
            end
            ST_LOW: begin
                if (stop_req) begin
                    state_d = ST_IDLE;
                end else if (adv) begin
                    state_d = ST_HIGH;
                end
            end
            ST_HIGH: begin
                if (stop_req) begin
                    state_d = ST_IDLE;
                end else if (adv) begin
                    state_d = last_bit ? ST_IDLE : ST_LOW;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            bit_cnt_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE) begin
                bit_cnt_q <= '0;
            end else if (sample_en) begin
                bit_cnt_q <= bit_cnt_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        sck_int   = (state_q != ST_LOW);
        sample_en = (state_q == ST_LOW) && adv && !stop_req;
        shift_en  = (state_q == ST_HIGH) && adv && !stop_req;
        finish    = shift_en && last_bit;
        phase_clr = (state_d != state_q) || (state_q == ST_IDLE);
        state     = state_q;
        bit_cnt   = bit_cnt_q;
    end
endmodule

// File: rtl/sio8_shreg.sv
`timescale 1ns/1ps
module sio8_shreg #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            msb_first,
    input  logic            load_en,
    input  logic [BITS-1:0] load_val,
    input  logic            sample_en,
    input  logic            si,
    input  logic            shift_en,
    output logic [BITS-1:0] data_q,
    output logic            ser_out
);
    logic si_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            si_q   <= 1'b0;
        end else begin
            if (sample_en) begin
                si_q <= si;
            end
            if (load_en) begin
                data_q <= load_val;
            end else if (shift_en) begin
                if (msb_first) begin
                    data_q <= {data_q[BITS-2:0], si_q};
                end else begin
                    data_q <= {si_q, data_q[BITS-1:1]};
                end
            end
        end
    end

    assign ser_out = msb_first ? data_q[BITS-1] : data_q[0];
endmodule

// File: rtl/sio8_shifter.sv
`timescale 1ns/1ps
module sio8_shifter
    import sio8_pkg::*;
#(
    parameter int P_FAST      = 2,
    parameter int P_MID       = 8,
    parameter int P_SLOW      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       reg_addr,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       si_pin,
    input  logic       sck_pin_i,
    input  logic       gpio_so_val,
    input  logic       gpio_sck_val,
    input  logic       gpio_sck_oe,
    output logic       so_pin_o,
    output logic       sck_pin_o,
    output logic       sck_pin_oe,
    output logic       irq
);
    localparam int CW = $clog2(SIO_BITS + 1);

    logic wr_mode, wr_data, start_req, stop_req, ext_mode;
    logic irq_en_q, ck_drv_q, so_drv_q, msb_first_q, done_q;
    logic [1:0] rate_q;
    logic phase_done, ext_rise, ext_fall;
    logic busy, sck_int, phase_clr, sample_en, shift_en, finish;
    logic [CW-1:0] bit_cnt;
    sio_state_e state;
    logic [SIO_BITS-1:0] data_q;
    logic ser_out;

    assign wr_mode   = reg_wr && !reg_addr;
    assign wr_data   = reg_wr && reg_addr;
    assign start_req = wr_mode && reg_wdata[0];
    assign stop_req  = wr_mode && !reg_wdata[0];
    assign ext_mode  = wr_mode ? (reg_wdata[3:2] == RATE_EXT) : (rate_q == RATE_EXT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_en_q    <= 1'b0;
            ck_drv_q    <= 1'b0;
            so_drv_q    <= 1'b0;
            rate_q      <= 2'b00;
            msb_first_q <= 1'b0;
        end else if (wr_mode) begin
            irq_en_q    <= reg_wdata[6];
            ck_drv_q    <= reg_wdata[5];
            so_drv_q    <= reg_wdata[4];
            rate_q      <= reg_wdata[3:2];
            msb_first_q <= reg_wdata[1];
        end
    end

    // completion flag: set wins over a clearing write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else if (finish) begin
            done_q <= 1'b1;
        end else if (wr_mode && !reg_wdata[7]) begin
            done_q <= 1'b0;
        end
    end

    sio8_clkgen #(
        .P_FAST(P_FAST), .P_MID(P_MID), .P_SLOW(P_SLOW), .SYNC_STAGES(SYNC_STAGES)
    ) u_clkgen (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rate(rate_q),
        .phase_clr(phase_clr), .sck_in(sck_pin_i),
        .phase_done(phase_done), .ext_rise(ext_rise), .ext_fall(ext_fall)
    );

    sio8_ctrl #(.BITS(SIO_BITS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
        .ext_mode(ext_mode), .phase_done(phase_done), .ext_rise(ext_rise),
        .ext_fall(ext_fall), .state(state), .busy(busy), .sck_int(sck_int),
        .phase_clr(phase_clr), .sample_en(sample_en), .shift_en(shift_en),
        .finish(finish), .bit_cnt(bit_cnt)
    );

    sio8_shreg #(.BITS(SIO_BITS)) u_shreg (
        .clk(clk), .rst_n(rst_n), .msb_first(msb_first_q),
        .load_en(wr_data && !busy), .load_val(reg_wdata),
        .sample_en(sample_en), .si(si_pin), .shift_en(shift_en),
        .data_q(data_q), .ser_out(ser_out)
    );

    assign reg_rdata  = reg_addr ? data_q
                                 : {done_q, irq_en_q, ck_drv_q, so_drv_q, rate_q, msb_first_q, busy};
    assign so_pin_o   = so_drv_q ? ser_out : gpio_so_val;
    assign sck_pin_o  = ck_drv_q ? sck_int : gpio_sck_val;
    assign sck_pin_oe = ck_drv_q ? 1'b1 : gpio_sck_oe;
    assign irq        = irq_en_q & done_q;
endmodule

// File: rtl/sio8_checker.sv
`timescale 1ns/1ps
module sio8_checker
    import sio8_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic       irq,
    input logic       stop_req,
    input logic       wr_mode,
    input logic       keep_bit,
    input logic       wr_data,
    input sio_state_e state,
    input logic       ser_out,
    input logic [3:0] bit_cnt,
    input logic [7:0] data_q
);
    p_bitcnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= 4'd8);

    p_done_on_finish_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !$past(stop_req)) |-> done);

    p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !(wr_mode && !keep_bit)) |=> done);

    p_irq_needs_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done);

    p_so_stable_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HIGH && $past(state) == ST_HIGH) |-> $stable(ser_out));

    p_data_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy) && !$past(wr_data)) |-> $stable(data_q));
endmodule

bind sio8_shifter sio8_checker u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done_q), .irq(irq),
    .stop_req(stop_req), .wr_mode(wr_mode), .keep_bit(reg_wdata[7]),
    .wr_data(wr_data), .state(state), .ser_out(ser_out),
    .bit_cnt(bit_cnt), .data_q(data_q)
);

// File: tb/test_sio8_shifter.sv
`timescale 1ns/1ps
module test_sio8_shifter;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst_n, tick, reg_addr, reg_wr;
    logic [7:0] reg_wdata, reg_rdata;
    logic       si_pin, sck_pin_i, gpio_so_val, gpio_sck_val, gpio_sck_oe;
    logic       so_pin_o, sck_pin_o, sck_pin_oe, irq;

    int n_chk = 0;
    int n_fail = 0;

    sio8_shifter i_sio8_shifter (
        .clk(clk), .rst_n(rst_n), .tick(tick), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .si_pin(si_pin),
        .sck_pin_i(sck_pin_i), .gpio_so_val(gpio_so_val), .gpio_sck_val(gpio_sck_val),
        .gpio_sck_oe(gpio_sck_oe), .so_pin_o(so_pin_o), .sck_pin_o(sck_pin_o),
        .sck_pin_oe(sck_pin_oe), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] mk(input bit dn, input bit ie, input bit ck, input bit so,
                                      input logic [1:0] rate, input bit msbf, input bit go);
        return {dn, ie, ck, so, rate, msbf, go};
    endfunction

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        reg_addr = a;
        #0.5;
        v = reg_rdata;
        reg_addr = 1'b0;
        #0.5;
    endtask

    task automatic xfer_int(input logic [7:0] tx, input logic [7:0] rx, input logic [1:0] rate,
                            input bit msbf, input bit ie, input int pause_at, input int pause_len,
                            input bit mid_wr);
        int p, k, nfall, nrise;
        logic prev, s, bsy;
        logic [7:0] cap, expo, v;
        p = (rate == 2'd0) ? 2 : (rate == 2'd1) ? 8 : 32;
        wr(1'b1, tx);
        chk(sck_pin_o == 1'b1, "R3", "sck idle high", sck_pin_o, 1);
        wr(1'b0, mk(0, ie, 1, 1, rate, msbf, 1));
        k = 0; nfall = 0; nrise = 0; prev = 1'b1; cap = 8'h00;
        while (k < 4000) begin
            if (mid_wr && k == 6) begin
                reg_wr = 1'b0; reg_addr = 1'b0;
            end
            #1;
            s = sck_pin_o;
            bsy = reg_rdata[0];
            if (prev && !s) begin
                if (nfall < 8) si_pin = msbf ? rx[7 - nfall] : rx[nfall];
                nfall++;
            end
            if (!prev && s) begin
                if (nrise < 8) cap[nrise] = so_pin_o;
                nrise++;
            end
            prev = s;
            if (k == pause_at) tick = 1'b0;
            if (k == pause_at + pause_len) tick = 1'b1;
            if (mid_wr && k == 5) begin
                reg_addr = 1'b1; reg_wdata = 8'h55; reg_wr = 1'b1;
            end
            if (!bsy) break;
            @(negedge clk);
            k++;
        end
        chk(reg_rdata[7] == 1'b1, "R6", "done with busy clear", reg_rdata[7], 1);
        chk(k == 8 * p + pause_len, "R3", "transfer length", k, 8 * p + pause_len);
        chk(nrise == 8 && nfall == 8, "R2", "edge count", nrise * 16 + nfall, 8 * 16 + 8);
        for (int j = 0; j < 8; j++) expo[j] = msbf ? tx[7 - j] : tx[j];
        chk(cap == expo, "R4", "bit order on pin", cap, expo);
        rd(1'b1, v);
        chk(v == rx, mid_wr ? "R11" : "R4", "received byte", v, rx);
        rd(1'b0, v);
        chk(v[0] == 1'b0, "R2", "go self-clear", v[0], 0);
        chk(irq == ie, "R7", "irq after done", irq, ie);
        chk(sck_pin_o == 1'b1, "R3", "sck high after", sck_pin_o, 1);
    endtask

    task automatic xfer_ext(input logic [7:0] tx, input logic [7:0] rx, input bit msbf);
        localparam int HP = 6;
        logic [7:0] cap, expo, v;
        wr(1'b1, tx);
        wr(1'b0, mk(0, 0, 0, 1, 2'b11, msbf, 1));
        #1;
        chk(reg_rdata[0] == 1'b1, "R5", "busy armed", reg_rdata[0], 1);
        chk(sck_pin_o == gpio_sck_val && sck_pin_oe == gpio_sck_oe, "R9", "sck to port",
            {sck_pin_o, sck_pin_oe}, {gpio_sck_val, gpio_sck_oe});
        repeat (3) @(negedge clk);
        for (int b = 0; b < 8; b++) begin
            sck_pin_i = 1'b0;
            si_pin = msbf ? rx[7 - b] : rx[b];
            repeat (HP) @(negedge clk);
            cap[b] = so_pin_o;
            sck_pin_i = 1'b1;
            repeat (HP) @(negedge clk);
        end
        for (int j = 0; j < 8; j++) expo[j] = msbf ? tx[7 - j] : tx[j];
        chk(cap == expo, "R5", "ext bit order", cap, expo);
        rd(1'b0, v);
        chk(v[0] == 1'b0 && v[7] == 1'b1, "R5", "ext complete", v, 8'h80);
        rd(1'b1, v);
        chk(v == rx, "R5", "ext received", v, rx);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] v;
        rst_n = 1'b0; tick = 1'b1; reg_addr = 1'b0; reg_wr = 1'b0; reg_wdata = 8'h00;
        si_pin = 1'b0; sck_pin_i = 1'b1; gpio_so_val = 1'b1; gpio_sck_val = 1'b0; gpio_sck_oe = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        rd(1'b0, v); chk(v == 8'h00, "R1", "mode reset", v, 0);
        rd(1'b1, v); chk(v == 8'h00, "R1", "data reset", v, 0);
        chk(irq == 1'b0, "R1", "irq reset", irq, 0);
        chk(so_pin_o == 1'b1, "R8", "so from port", so_pin_o, 1);
        gpio_so_val = 1'b0; #0.5;
        chk(so_pin_o == 1'b0, "R8", "so follows port", so_pin_o, 0);
        chk(sck_pin_o == 1'b0 && sck_pin_oe == 1'b0, "R9", "sck from port",
            {sck_pin_o, sck_pin_oe}, 0);

        wr(1'b1, 8'h96);
        rd(1'b1, v); chk(v == 8'h96, "R11", "idle data write", v, 8'h96);
        wr(1'b0, mk(0, 0, 1, 1, 2'b00, 0, 0));
        #0.5;
        chk(so_pin_o == 1'b0, "R8", "so serial lsb", so_pin_o, 0);
        chk(sck_pin_o == 1'b1 && sck_pin_oe == 1'b1, "R9", "sck driven idle",
            {sck_pin_o, sck_pin_oe}, 3);
        wr(1'b0, mk(0, 0, 1, 1, 2'b00, 1, 0));
        #0.5;
        chk(so_pin_o == 1'b1, "R8", "so serial msb", so_pin_o, 1);

        for (int r = 0; r < 3; r++) begin
            for (int m = 0; m < 2; m++) begin
                for (int i = 0; i < 10; i++) begin
                    logic [7:0] t, x;
                    t = 8'(i * 73 + r * 29 + m);
                    x = 8'(~t ^ (i * 16));
                    if (i == 0) begin t = 8'h00; x = 8'hFF; end
                    if (i == 1) begin t = 8'hFF; x = 8'h00; end
                    xfer_int(t, x, 2'(r), m[0], i[0], -1, 0, 1'b0);
                end
            end
        end

        wr(1'b0, mk(1, 0, 1, 1, 2'b00, 0, 0));
        rd(1'b0, v);
        chk(v[7] == 1'b1, "R6", "write 1 keeps done", v[7], 1);
        chk(irq == 1'b0, "R7", "irq masked", irq, 0);
        wr(1'b0, mk(1, 1, 1, 1, 2'b00, 0, 0));
        #0.5;
        chk(irq == 1'b1, "R7", "irq enabled", irq, 1);
        wr(1'b0, mk(0, 1, 1, 1, 2'b00, 0, 0));
        rd(1'b0, v);
        chk(v[7] == 1'b0, "R6", "write 0 clears done", v[7], 0);
        chk(irq == 1'b0, "R7", "irq after clear", irq, 0);

        xfer_int(8'hA5, 8'h3C, 2'b00, 1'b0, 1'b0, 3, 50, 1'b0);
        xfer_int(8'h5A, 8'hC3, 2'b01, 1'b1, 1'b1, -1, 0, 1'b1);

        wr(1'b0, mk(0, 1, 1, 1, 2'b00, 0, 0));
        wr(1'b1, 8'hC3);
        wr(1'b0, mk(0, 1, 1, 1, 2'b10, 0, 1));
        repeat (20) @(negedge clk);
        wr(1'b0, mk(0, 1, 1, 1, 2'b10, 0, 0));
        rd(1'b0, v);
        chk(v[0] == 1'b0, "R10", "stop clears go", v[0], 0);
        chk(sck_pin_o == 1'b1, "R10", "stop sck high", sck_pin_o, 1);
        repeat (300) @(negedge clk);
        rd(1'b0, v);
        chk(v[7] == 1'b0 && v[0] == 1'b0, "R10", "no done after stop", v, 0);
        chk(irq == 1'b0, "R10", "no irq after stop", irq, 0);

        gpio_sck_val = 1'b1; gpio_sck_oe = 1'b0;
        xfer_ext(8'h81, 8'h6E, 1'b0);
        xfer_ext(8'h81, 8'h6E, 1'b1);
        xfer_ext(8'h3D, 8'hF0, 1'b0);
        xfer_ext(8'hC6, 8'h1B, 1'b1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule